// File: doc/BRIEF.md
# Truncated Fixed-Point Fractional Multiplier

This block multiplies two unsigned N-bit fractions and returns only the N most significant bits of the product. Operand bit `x[N-1]` is worth 2^-1 and bit `x[0]` is worth 2^-N, and the product uses the same scale. Only the upper part of the partial-product array is built. Column c collects the products a_i·b_j with i+j = c, where i and j count fraction bits from the binary point. The columns after the kept region are dropped. The column just past the kept region is counted at the weight of the last kept column. A fixed pattern of ones covers the bias of the final truncation. The result is therefore an approximation, held within one unit in the last place of the exact product when the correction width K is chosen to suit N.

The operands go straight into the column logic, and the kept columns are reduced to one sum. When `OUT_REG` is set, the top N bits of that sum are captured in a single register. That register clears to zero on the asynchronous active-low reset. With `OUT_REG` cleared, the path from the operands to `p` is purely combinational.

Top module: `trunc_frac_mul`

## Requirements
- R1: A product a_i·b_j with i+j ≥ N+K+2 has no effect on `p`. With N=8 and K=2, `a`=0x03 and `b`=0x03 give `p`=0x00.
- R2: The products with i+j = N+K+1 are each added with the weight of column N+K. With N=8 and K=2, `a`=0x30 and `b`=0x03 give `p`=0x01.
- R3: Columns N+2 to N+K each receive one injected one, which adds 2^(K-1)−1 units of 2^-(N+K) when K ≥ 2. With N=8 and K=2, `a`=0xC0 and `b`=0x01 give `p`=0x01.
- R4: `p` equals floor(S / 2^K). S is the sum of a_i·b_j·2^(N+K−i−j) over i+j ≤ N+K, plus the folded bits of R2, plus the injected ones of R3. S stays below 2^(N+K). With N=8 and K=2, 0xFF times 0xFF gives 0xFE.
- R5: A zero on either operand gives `p` = 0.
- R6: For K ≥ 1, `a` = 1/2 (only bit N-1 set) gives `p` = `b` >> 1.
- R7: |p·2^N − a·b| < 2^N for every operand pair when K follows this rule: K=0 for N≤3, 1 for N≤7, 2 for 8–14, 3 for 15–27, 4 for 28–52, 5 for 53–101, 6 for 102–198.
- R8: `p` never exceeds either operand.
- R9: Swapping `a` and `b` leaves `p` unchanged.
- R10: With `OUT_REG`=1, `p` reads 0 while `rst_n` is low, and the product of the operands present at a rising clock edge appears on `p` after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | N | Multiplicand fraction, MSB worth 2^-1 |
| b | input | N | Multiplier fraction, MSB worth 2^-1 |
| p | output | N | Truncated product fraction |

## Verification
The bench walks all 65,536 operand pairs at N=8, K=2 and compares each one against a bit-level model of the kept columns. It also checks the one-ulp bound against the exact 16-bit product.

Hand-picked pairs isolate each correction term. A design that kept one column too many, or dropped the folded column, would give 0 instead of 1 for 0x30×0x03. One that left out the injected ones would give 0 for 0xC0×0x01. One that let the sum carry out of its top column would wrap 0xFF×0xFF towards zero.

Swapped random pairs expose any asymmetry in how rows and columns are enumerated. The reset and first-vector checks catch a register that comes out of reset with a stale value or adds a cycle of delay.

// File: rtl/trunc_frac_mul.sv
module trunc_frac_mul #(
  parameter int N       = 8,
  parameter int K       = 2,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] p
);
  localparam int TOP = N + K;
  localparam int SW  = TOP + 1;
  localparam int CW  = $clog2(N + 1);

  // R3: one injected one per column N+2 .. N+K
  function automatic logic [SW-1:0] inject_val();
    logic [SW-1:0] v;
    v = '0;
    for (int c = N + 2; c <= TOP; c++) v[TOP-c] = 1'b1;
    return v;
  endfunction

  localparam logic [SW-1:0] INJECT = inject_val();

  logic [CW-1:0] cnt [2:TOP+1];
  logic [SW-1:0] sum;
  logic [N-1:0]  prod;

  // R1: only columns 2 .. N+K+1 exist
  for (genvar c = 2; c <= TOP + 1; c++) begin : g_col
    localparam int LO = (c - N > 1) ? c - N : 1;
    localparam int HI = (c - 1 < N) ? c - 1 : N;
    localparam int H  = HI - LO + 1;
    logic [H-1:0] bits;
    for (genvar i = LO; i <= HI; i++) begin : g_pp
      assign bits[i-LO] = a[N-i] & b[N-(c-i)];
    end
    assign cnt[c] = CW'($countones(bits));
  end

  // R2 / R4: weighted column sum, last column folded to unit weight
  always_comb begin
    sum = INJECT;
    for (int c = 2; c <= TOP; c++) sum = sum + (SW'(cnt[c]) << (TOP - c));
    sum = sum + SW'(cnt[TOP+1]);
  end

  assign prod = sum[TOP-1:K];

  // R10
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p <= '0;
      else        p <= prod;
    end
  end else begin : g_comb
    assign p = prod;
  end
endmodule

module trunc_frac_mul_chk #(
  parameter int N       = 8,
  parameter int K       = 2,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [N-1:0] p,
  input logic [N+K:0] sum
);
  localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};
  localparam logic [2*N:0] ULP  = {{N{1'b0}}, 1'b1, {N{1'b0}}};

  logic [N-1:0] oa, ob;
  if (OUT_REG) begin : g_q
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oa <= '0;
        ob <= '0;
      end else begin
        oa <= a;
        ob <= b;
      end
    end
  end else begin : g_c
    assign oa = a;
    assign ob = b;
  end

  logic [2*N:0] exact, scaled, diff;
  assign exact  = {{(N+1){1'b0}}, oa} * {{(N+1){1'b0}}, ob};
  assign scaled = {1'b0, p, {N{1'b0}}};
  assign diff   = (scaled >= exact) ? scaled - exact : exact - scaled;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum[N+K] == 1'b0);

  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oa == '0 || ob == '0) |-> (p == '0));

  // R7
  ulp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diff < ULP);

  // R8
  below_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p <= oa) && (p <= ob));

  if (K >= 1) begin : g_half
    // R6
    half_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oa == HALF) |-> (p == (ob >> 1)));
  end
endmodule

bind trunc_frac_mul trunc_frac_mul_chk #(.N(N), .K(K), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p), .sum(sum)
);

// File: tb/trunc_frac_mul_test.sv
module trunc_frac_mul_test;
  localparam int N = 8;
  localparam int K = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] b_i = '0;
  logic [N-1:0] p_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int unsigned qa[$];
  int unsigned qb[$];
  int unsigned qe[$];
  string       qt[$];

  always #4 clk = ~clk;

  trunc_frac_mul #(.N(N), .K(K), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .a(a_i), .b(b_i), .p(p_o)
  );

  function automatic int unsigned model(int unsigned x, int unsigned y);
    int unsigned s;
    s = 0;
    for (int i = 1; i <= N; i++)
      for (int j = 1; j <= N; j++)
        if (((x >> (N - i)) & 1) == 1 && ((y >> (N - j)) & 1) == 1) begin
          if (i + j <= N + K)          s += 1 << (N + K - i - j);
          else if (i + j == N + K + 1) s += 1;
        end
    for (int c = N + 2; c <= N + K; c++) s += 1 << (N + K - c);
    return s >> K;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned expv, bit ok);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic pop_check();
    int unsigned ea, eb, ee, prod, sc, d;
    string t;
    if (qa.size() == 0) return;
    ea = qa.pop_front(); eb = qb.pop_front(); ee = qe.pop_front(); t = qt.pop_front();
    check(t, p_o, ee, p_o == N'(ee));
    prod = ea * eb;
    sc   = int'(p_o) << N;
    d    = (sc >= prod) ? sc - prod : prod - sc;
    check("R7", d, 1 << N, d < (1 << N));
    check("R8", p_o, (ea < eb) ? ea : eb, p_o <= N'(ea) && p_o <= N'(eb));
  endtask

  task automatic step(int unsigned x, int unsigned y, int unsigned expv, string req);
    @(negedge clk);
    pop_check();
    a_i = N'(x);
    b_i = N'(y);
    qa.push_back(x); qb.push_back(y); qe.push_back(expv); qt.push_back(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", p_o, 0, p_o == '0);
    a_i = 8'hFF; b_i = 8'hFF;
    @(negedge clk);
    check("R10", p_o, 0, p_o == '0);
    rst_n = 1'b1;

    step(8'hFF, 8'hFF, 8'hFE, "R10");
    step(8'h03, 8'h03, 8'h00, "R1");
    step(8'h30, 8'h03, 8'h01, "R2");
    step(8'hC0, 8'h01, 8'h01, "R3");
    step(8'hFF, 8'hFF, 8'hFE, "R4");
    step(8'h00, 8'hFF, 8'h00, "R5");
    step(8'hA5, 8'h00, 8'h00, "R5");
    step(8'h80, 8'hB7, 8'h5B, "R6");
    step(8'h80, 8'h01, 8'h00, "R6");

    for (int r = 0; r < 200; r++) begin
      int unsigned x, y;
      x = $urandom_range(255);
      y = $urandom_range(255);
      step(x, y, model(x, y), "R9");
      step(y, x, model(x, y), "R9");
    end

    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        step(x, y, model(x, y), "R4");

    @(negedge clk);
    pop_check();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule